// File: doc/BRIEF.md
# Fault-Injectable Word RAM

A single-port word memory that behaves as an ideal RAM until a fault is dialled in at its configuration inputs. It then shows exactly one classic functional memory defect: a stuck cell, a cell that refuses one transition, an inversion or idempotent coupling between two cells, a level-driven state coupling, an AND or OR short between two cells, or an address that the decoder cannot reach. A March test engine drives it as an ordinary RAM, and its verdicts can then be compared with the fault that was injected.

Each clock cycle is either a write (`we` high) or a read (`we` low). Write-side faults (stuck, transition, both couplings) change what is stored. Read-side faults (stuck, state coupling, bridging) change what is returned. The access address is split inside the decoder, low bits selecting the column and high bits the row. When aliasing is active, the unreachable address is steered onto another word. A small access state machine registers the result. From reset it sits in `ST_IDLE`. On any edge it moves to `ST_WRITE` when `we` is high, to `ST_NOISE` on a read of the unreachable address, and to `ST_READ` on any other read. `rdata` loads in `ST_READ` and `ST_NOISE` and holds in `ST_WRITE`. In `ST_NOISE` the value comes from a pseudo-random generator that steps once per such read.

Top module: `fim_ram`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0 at once, every word is cleared to 0 and the noise generator is reloaded with its seed.
- R2: With `flt_kind` = 0 (no fault), a read returns on `rdata` one clock edge later the last value written to that address.
- R3: With `flt_kind` = 1 (stuck), bit `vic_bit` of word `vic_addr` always reads as `flt_val`, whatever is written.
- R4: With `flt_kind` = 2 (transition), the victim bit cannot rise from 0 to 1 when `flt_dir` = 1, or fall from 1 to 0 when `flt_dir` = 0. The opposite transition still works.
- R5: With `flt_kind` = 3 (inversion coupling), a write that moves the aggressor bit to `flt_dir` inverts the victim bit on the same edge. A write that leaves the aggressor bit unchanged, or moves it the other way, has no effect on the victim.
- R6: With `flt_kind` = 4 (idempotent coupling), a write that moves the aggressor bit to `flt_dir` sets the victim bit to `flt_val`. A move in the other direction has no effect.
- R7: With `flt_kind` = 5 (state coupling), the victim bit reads as `flt_val` while the stored aggressor bit equals `flt_lvl`, and reads as its own stored value otherwise.
- R8: With `flt_kind` = 6 (AND bridge) or 7 (OR bridge), reading either the victim or the aggressor word returns the AND or the OR of the two stored bits in that bit position.
- R9: With `flt_kind` = 8 (aliasing) and `vic_addr` ≠ `agg_addr`, a write to `vic_addr` lands in word `agg_addr`, and the stored word at `vic_addr` is left unchanged.
- R10: With aliasing active, a read of `vic_addr` returns the low DATA_W bits of a 16-bit shift register after one step. The step shifts left and feeds bit 0 with the XOR of bits 15, 13, 12 and 10. The register's seed is 0xACE1, and it steps only on such reads.
- R11: `flt_kind` codes 9 to 15 behave exactly as code 0.
- R12: On a write cycle `rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (4) | Access address |
| we | input | 1 | 1 = write this cycle, 0 = read |
| wdata | input | DATA_W (8) | Write data |
| flt_kind | input | 4 | Fault selection code (see requirements) |
| vic_addr | input | ADDR_W (4) | Victim word (unreachable word for aliasing) |
| vic_bit | input | log2(DATA_W) (3) | Victim bit position |
| agg_addr | input | ADDR_W (4) | Aggressor word (alias target for aliasing) |
| agg_bit | input | log2(DATA_W) (3) | Aggressor bit position |
| flt_dir | input | 1 | Triggering or blocked transition: 1 = rising, 0 = falling |
| flt_val | input | 1 | Stuck or forced victim value |
| flt_lvl | input | 1 | Aggressor level that activates state coupling |
| rdata | output | DATA_W (8) | Registered read data |

## Verification
Every read result appears on `rdata` after exactly one rising edge. Coupling effects land in storage on the edge of the aggressor write, so the earliest read that can show them is issued in the next cycle and answers one edge after that. The bench drives each vector just after a falling edge and samples `rdata` one nanosecond after the following rising edge, which is the first instant the result is due. Write cycles that follow a read are sampled the same way, to confirm that `rdata` did not move.

// File: rtl/fim_pkg.sv
package fim_pkg;

    typedef enum logic [3:0] {
        FK_NONE   = 4'd0,
        FK_STUCK  = 4'd1,
        FK_TRANS  = 4'd2,
        FK_CINV   = 4'd3,
        FK_CIDEM  = 4'd4,
        FK_CSTATE = 4'd5,
        FK_BAND   = 4'd6,
        FK_BOR    = 4'd7,
        FK_ALIAS  = 4'd8
    } fault_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_NOISE = 2'd3
    } acc_state_e;

endpackage

// File: rtl/fim_decode.sv
module fim_decode #(
    parameter int ADDR_W = 4,
    parameter int COL_W  = 2
) (
    input  logic              alias_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] vic_addr,
    input  logic [ADDR_W-1:0] agg_addr,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              unreach
);
    localparam int ROW_W = ADDR_W - COL_W;

    logic [ADDR_W-1:0] steered;
    logic [ROW_W-1:0]  row_sel;
    logic [COL_W-1:0]  col_sel;

    always_comb begin
        unreach = alias_en && (addr == vic_addr) && (vic_addr != agg_addr);
        steered = unreach ? agg_addr : addr;
        row_sel = steered[ADDR_W-1:COL_W];
        col_sel = steered[COL_W-1:0];
        phys_addr = {row_sel, col_sel};
    end

    always_comb begin
        if (unreach) begin
            a_r9_steer_to_target: assert (phys_addr == agg_addr);
        end
    end
endmodule

// File: rtl/fim_lfsr.sv
module fim_lfsr #(
    parameter int          LFSR_W = 16,
    parameter int          OUT_W  = 8,
    parameter logic [15:0] TAPS   = 16'hB400,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] noise
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_d;
    logic              fb;

    always_comb begin
        fb     = ^(lfsr_q & TAPS[LFSR_W-1:0]);
        lfsr_d = {lfsr_q[LFSR_W-2:0], fb};
        noise  = lfsr_d[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lfsr_q <= SEED[LFSR_W-1:0];
        else if (step) lfsr_q <= lfsr_d;
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r10_never_zero: assert (lfsr_q != '0);
        end
    end
endmodule

// File: rtl/fim_array.sv
module fim_array
    import fim_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [3:0]        kind,
    input  logic [ADDR_W-1:0] vic_addr,
    input  logic [BIT_W-1:0]  vic_bit,
    input  logic [ADDR_W-1:0] agg_addr,
    input  logic [BIT_W-1:0]  agg_bit,
    input  logic              flt_dir,
    input  logic              flt_val,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword,
    output logic              vic_cell,
    output logic              agg_cell
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic [DEPTH-1:0][DATA_W-1:0] mem_d;
    logic [DATA_W-1:0]            old_w;
    logic [DATA_W-1:0]            new_w;
    logic                         trig;

    // write-side fault behaviour
    always_comb begin
        mem_d = mem_q;
        old_w = mem_q[waddr];
        new_w = wdata;
        trig  = 1'b0;
        if (we) begin
            if (kind == FK_TRANS && waddr == vic_addr) begin
                if (flt_dir && !old_w[vic_bit] && wdata[vic_bit])
                    new_w[vic_bit] = 1'b0;
                if (!flt_dir && old_w[vic_bit] && !wdata[vic_bit])
                    new_w[vic_bit] = 1'b1;
            end
            if (kind == FK_STUCK && waddr == vic_addr)
                new_w[vic_bit] = flt_val;
            mem_d[waddr] = new_w;
            trig = (waddr == agg_addr) && (old_w[agg_bit] != new_w[agg_bit])
                   && (new_w[agg_bit] == flt_dir);
            if (trig && kind == FK_CINV)
                mem_d[vic_addr][vic_bit] = ~mem_d[vic_addr][vic_bit];
            if (trig && kind == FK_CIDEM)
                mem_d[vic_addr][vic_bit] = flt_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        rword    = mem_q[raddr];
        vic_cell = mem_q[vic_addr][vic_bit];
        agg_cell = mem_q[agg_addr][agg_bit];
    end

    // R4: a blocked rising transition leaves the victim at 0
    a_r4_rise_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == FK_TRANS && waddr == vic_addr && flt_dir && !mem_q[vic_addr][vic_bit])
        |=> !mem_q[$past(vic_addr)][$past(vic_bit)]);

    // R5: an aggressor write without a bit change leaves the victim alone
    a_r5_no_change_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == FK_CINV && waddr == agg_addr && vic_addr != agg_addr
         && wdata[agg_bit] == mem_q[agg_addr][agg_bit])
        |=> mem_q[$past(vic_addr)][$past(vic_bit)] == $past(mem_q[vic_addr][vic_bit]));

    // R6: an idempotent trigger leaves the victim at the forced value
    a_r6_forced_value: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == FK_CIDEM && waddr == agg_addr && vic_addr != agg_addr
         && wdata[agg_bit] == flt_dir && mem_q[agg_addr][agg_bit] != flt_dir)
        |=> mem_q[$past(vic_addr)][$past(vic_bit)] == $past(flt_val));
endmodule

// File: rtl/fim_ram.sv
module fim_ram
    import fim_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 8,
    parameter int          COL_W     = 2,
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       we,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [3:0]                 flt_kind,
    input  logic [ADDR_W-1:0]          vic_addr,
    input  logic [$clog2(DATA_W)-1:0]  vic_bit,
    input  logic [ADDR_W-1:0]          agg_addr,
    input  logic [$clog2(DATA_W)-1:0]  agg_bit,
    input  logic                       flt_dir,
    input  logic                       flt_val,
    input  logic                       flt_lvl,
    output logic [DATA_W-1:0]          rdata
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [ADDR_W-1:0] phys;
    logic              unreach;
    logic [DATA_W-1:0] raw_word;
    logic              vic_cell;
    logic              agg_cell;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] noise;
    logic              bridge;
    acc_state_e        state_q;
    acc_state_e        state_d;

    fim_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_decode (
        .alias_en (flt_kind == FK_ALIAS),
        .addr     (addr),
        .vic_addr (vic_addr),
        .agg_addr (agg_addr),
        .phys_addr(phys),
        .unreach  (unreach)
    );

    fim_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (phys),
        .wdata   (wdata),
        .kind    (flt_kind),
        .vic_addr(vic_addr),
        .vic_bit (vic_bit),
        .agg_addr(agg_addr),
        .agg_bit (agg_bit),
        .flt_dir (flt_dir),
        .flt_val (flt_val),
        .raddr   (phys),
        .rword   (raw_word),
        .vic_cell(vic_cell),
        .agg_cell(agg_cell)
    );

    fim_lfsr #(.LFSR_W(LFSR_W), .OUT_W(DATA_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (state_d == ST_NOISE),
        .noise(noise)
    );

    // read-side fault behaviour
    always_comb begin
        rd_word = raw_word;
        bridge  = (flt_kind == FK_BAND) ? (vic_cell & agg_cell) : (vic_cell | agg_cell);
        if (flt_kind == FK_STUCK && phys == vic_addr)
            rd_word[vic_bit] = flt_val;
        if (flt_kind == FK_CSTATE && phys == vic_addr && agg_cell == flt_lvl)
            rd_word[vic_bit] = flt_val;
        if (flt_kind == FK_BAND || flt_kind == FK_BOR) begin
            if (phys == vic_addr) rd_word[vic_bit] = bridge;
            if (phys == agg_addr) rd_word[agg_bit] = bridge;
        end
    end

    // next access state
    always_comb begin
        if (we)           state_d = ST_WRITE;
        else if (unreach) state_d = ST_NOISE;
        else              state_d = ST_READ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (state_d)
                ST_READ:  rdata <= rd_word;
                ST_NOISE: rdata <= noise;
                ST_WRITE: rdata <= rdata;
                ST_IDLE:  rdata <= rdata;
            endcase
        end
    end

    // R12: a write cycle keeps the last read result
    a_r12_hold_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $stable(rdata));

    // R3: the stuck bit reads as the stuck value
    a_r3_stuck_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && flt_kind == FK_STUCK && addr == vic_addr)
        |=> rdata[$past(vic_bit)] == $past(flt_val));

    // R2: ideal write followed by read of the same word returns the data
    a_r2_ideal_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && $past(flt_kind) == FK_NONE && flt_kind == FK_NONE
         && !we && addr == $past(addr) && state_q == ST_WRITE)
        |=> rdata == $past(wdata, 2));

    // R10: a read of the unreachable word takes the noise path
    a_r10_noise_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && flt_kind == FK_ALIAS && addr == vic_addr && vic_addr != agg_addr)
        |=> state_q == ST_NOISE);
endmodule

// File: tb/fim_ram_tb.sv
module fim_ram_tb;

    typedef struct packed {
        logic       we;
        logic [3:0] addr;
        logic [7:0] wd;
        logic [3:0] kind;
        logic [3:0] vic;
        logic [2:0] vb;
        logic [3:0] agg;
        logic [2:0] ab;
        logic       dir;
        logic       val;
        logic       lvl;
        logic       chk;
        logic       nz;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t VECS [NV] = '{
        // R2 ideal RAM
        '{1'b1,4'd3, 8'h5A,4'd0,4'd0, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd2},
        '{1'b0,4'd3, 8'h00,4'd0,4'd0, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h5A,4'd2},
        '{1'b1,4'd12,8'hC3,4'd0,4'd0, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd2},
        '{1'b0,4'd12,8'h00,4'd0,4'd0, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'hC3,4'd2},
        '{1'b0,4'd3, 8'h00,4'd0,4'd0, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h5A,4'd2},
        // R3 stuck-at-1 on word 5 bit 2
        '{1'b0,4'd5, 8'h00,4'd1,4'd5, 3'd2,4'd0, 3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h04,4'd3},
        '{1'b1,4'd5, 8'h00,4'd1,4'd5, 3'd2,4'd0, 3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,4'd3},
        '{1'b0,4'd5, 8'h00,4'd1,4'd5, 3'd2,4'd0, 3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h04,4'd3},
        '{1'b1,4'd5, 8'hF0,4'd1,4'd5, 3'd2,4'd0, 3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,4'd3},
        '{1'b0,4'd5, 8'h00,4'd1,4'd5, 3'd2,4'd0, 3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,8'hF4,4'd3},
        // R4 transition fault on word 6 bit 0, rising blocked then falling blocked
        '{1'b1,4'd6, 8'hFF,4'd2,4'd6, 3'd0,4'd0, 3'd0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'd4},
        '{1'b0,4'd6, 8'h00,4'd2,4'd6, 3'd0,4'd0, 3'd0,1'b1,1'b0,1'b0,1'b1,1'b0,8'hFE,4'd4},
        '{1'b1,4'd6, 8'h01,4'd2,4'd6, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd4},
        '{1'b0,4'd6, 8'h00,4'd2,4'd6, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h01,4'd4},
        '{1'b1,4'd6, 8'h00,4'd2,4'd6, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd4},
        '{1'b0,4'd6, 8'h00,4'd2,4'd6, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h01,4'd4},
        // R5 inversion coupling: aggressor 8.1 rising, victim 9.7
        '{1'b1,4'd9, 8'h0F,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b1,4'd8, 8'h02,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b0,4'd9, 8'h00,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h8F,4'd5},
        '{1'b1,4'd8, 8'h03,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b0,4'd9, 8'h00,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h8F,4'd5},
        '{1'b1,4'd8, 8'h00,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b0,4'd9, 8'h00,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h8F,4'd5},
        '{1'b1,4'd8, 8'h02,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,4'd5},
        '{1'b0,4'd9, 8'h00,4'd3,4'd9, 3'd7,4'd8, 3'd1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h0F,4'd5},
        // R6 idempotent coupling: aggressor 10.0 falling forces victim 11.3 to 1
        '{1'b1,4'd11,8'h00,4'd4,4'd11,3'd3,4'd10,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,4'd6},
        '{1'b1,4'd10,8'h01,4'd4,4'd11,3'd3,4'd10,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,4'd6},
        '{1'b0,4'd11,8'h00,4'd4,4'd11,3'd3,4'd10,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,4'd6},
        '{1'b1,4'd10,8'h00,4'd4,4'd11,3'd3,4'd10,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,4'd6},
        '{1'b0,4'd11,8'h00,4'd4,4'd11,3'd3,4'd10,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h08,4'd6},
        '{1'b0,4'd10,8'h00,4'd4,4'd11,3'd3,4'd10,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,4'd6},
        // R7 state coupling: while 12.7 is 1, 13.0 reads 1
        '{1'b1,4'd13,8'h00,4'd5,4'd13,3'd0,4'd12,3'd7,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,4'd7},
        '{1'b0,4'd13,8'h00,4'd5,4'd13,3'd0,4'd12,3'd7,1'b0,1'b1,1'b1,1'b1,1'b0,8'h01,4'd7},
        '{1'b1,4'd12,8'h43,4'd5,4'd13,3'd0,4'd12,3'd7,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,4'd7},
        '{1'b0,4'd13,8'h00,4'd5,4'd13,3'd0,4'd12,3'd7,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,4'd7},
        '{1'b0,4'd12,8'h00,4'd5,4'd13,3'd0,4'd12,3'd7,1'b0,1'b1,1'b1,1'b1,1'b0,8'h43,4'd7},
        // R8 bridging between 14.4 and 15.4
        '{1'b1,4'd14,8'h10,4'd6,4'd14,3'd4,4'd15,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd8},
        '{1'b1,4'd15,8'h00,4'd6,4'd14,3'd4,4'd15,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd8},
        '{1'b0,4'd14,8'h00,4'd6,4'd14,3'd4,4'd15,3'd4,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,4'd8},
        '{1'b0,4'd15,8'h00,4'd6,4'd14,3'd4,4'd15,3'd4,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,4'd8},
        '{1'b0,4'd15,8'h00,4'd7,4'd14,3'd4,4'd15,3'd4,1'b0,1'b0,1'b0,1'b1,1'b0,8'h10,4'd8},
        '{1'b0,4'd14,8'h00,4'd7,4'd14,3'd4,4'd15,3'd4,1'b0,1'b0,1'b0,1'b1,1'b0,8'h10,4'd8},
        // R9 / R10 aliasing: word 2 unreachable, steered to word 7
        '{1'b1,4'd2, 8'h77,4'd8,4'd2, 3'd0,4'd7, 3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd9},
        '{1'b0,4'd7, 8'h00,4'd8,4'd2, 3'd0,4'd7, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h77,4'd9},
        '{1'b0,4'd2, 8'h00,4'd8,4'd2, 3'd0,4'd7, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,4'd10},
        '{1'b0,4'd2, 8'h00,4'd8,4'd2, 3'd0,4'd7, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,4'd10},
        '{1'b0,4'd2, 8'h00,4'd0,4'd0, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,4'd9},
        '{1'b0,4'd7, 8'h00,4'd0,4'd0, 3'd0,4'd0, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h77,4'd9},
        // R11 reserved code behaves as ideal
        '{1'b1,4'd4, 8'h3C,4'd12,4'd4,3'd0,4'd4, 3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd11},
        '{1'b0,4'd4, 8'h00,4'd12,4'd4,3'd0,4'd4, 3'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h3C,4'd11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [3:0] flt_kind = '0;
    logic [3:0] vic_addr = '0;
    logic [2:0] vic_bit = '0;
    logic [3:0] agg_addr = '0;
    logic [2:0] agg_bit = '0;
    logic       flt_dir = 1'b0;
    logic       flt_val = 1'b0;
    logic       flt_lvl = 1'b0;
    logic [7:0] rdata;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [15:0] mdl_lfsr = 16'hACE1;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    fim_ram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .flt_kind(flt_kind), .vic_addr(vic_addr), .vic_bit(vic_bit),
        .agg_addr(agg_addr), .agg_bit(agg_bit), .flt_dir(flt_dir),
        .flt_val(flt_val), .flt_lvl(flt_lvl), .rdata(rdata)
    );

    // noise model from R10: shift left, bit 0 <= b15^b13^b12^b10
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        we = v.we; addr = v.addr; wdata = v.wd; flt_kind = v.kind;
        vic_addr = v.vic; vic_bit = v.vb; agg_addr = v.agg; agg_bit = v.ab;
        flt_dir = v.dir; flt_val = v.val; flt_lvl = v.lvl;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [3:0] a);
        vec_t v;
        v = '0;
        v.addr = a;
        apply(v);
    endtask

    initial begin
        logic [7:0] expv;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset output", rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            if (VECS[i].chk) begin
                if (VECS[i].nz) begin
                    mdl_lfsr = lfsr_step(mdl_lfsr);
                    expv = mdl_lfsr[7:0];
                end else begin
                    expv = VECS[i].exp;
                end
                check($sformatf("R%0d vector %0d", VECS[i].req, i), rdata, expv);
            end
        end

        // R12: write after a read leaves rdata untouched
        rd(4'd3);
        check("R2 read word 3", rdata, 8'h5A);
        begin
            vec_t w;
            w = '0; w.we = 1'b1; w.addr = 4'd3; w.wd = 8'h11;
            apply(w);
        end
        check("R12 hold on write", rdata, 8'h5A);
        rd(4'd3);
        check("R2 readback after write", rdata, 8'h11);

        // R1: mid-run reset clears output, storage and noise seed
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", rdata, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(4'd12);
        check("R1 storage cleared", rdata, 8'h00);
        begin
            vec_t a;
            a = '0; a.kind = 4'd8; a.addr = 4'd2; a.vic = 4'd2; a.agg = 4'd7;
            apply(a);
        end
        check("R1 R10 noise reseeded", rdata, lfsr_step(16'hACE1) & 16'h00FF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: rdata=%02h expected=completion", rdata);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule